// File: doc/BRIEF.md
# Serial Capture and Replay Buffer

This block sits on a UART link to a host. Every byte the host sends is collected into an on-chip first-in first-out store of 256 entries and is not sent back immediately. When an operator presses a push-button, the block replays the collected bytes to the host in the order they arrived, one frame after another, until the store is empty. Once 256 bytes are held, any further arrivals are thrown away, so the earliest 256 survive.

Serial frames use 8 data bits, no parity and one stop bit, sent least significant bit first. The system clock and baud rate are parameters, with defaults of 50 MHz and 115200. The receiver samples the line at 16 times the bit rate. The button is resynchronised and debounced, with a default settling time of 20 ms. Inside the block, the receiver feeds the store through a valid strobe that has no back-pressure: a byte offered while the store is full is dropped. The store feeds the transmitter through a valid/ready pair in which ready means the transmitter is idle. A byte moves only on a cycle where both are high.

Top module: `cr_capture_replay`

## Requirements
- R1: While reset is held, and right after it is released, `tx_o` is high and `buf_full_o` is low. The store is empty, so a press sends nothing.
- R2: The receiver accepts frames with a low start bit, then 8 data bits sent least significant bit first, then a high stop bit, each bit lasting CLK_HZ/BAUD clocks. Each accepted frame writes its byte into the store.
- R3: A start bit is confirmed only if the line is still low at the middle of the bit. A low pulse shorter than half a bit stores nothing.
- R4: A frame whose stop bit is sampled low is discarded and stores nothing.
- R5: The store holds up to 256 bytes, and `buf_full_o` is high exactly while 256 are held. A byte that arrives while the store is full is dropped, and the bytes already held are left unchanged.
- R6: Received bytes are not echoed. Outside a replay, `tx_o` stays high.
- R7: Only the debounced press edge of `btn_i` (low to high) starts a replay. Contact bounce around a single press gives a single replay. A press while the store is empty sends nothing, and a press during a replay is ignored.
- R8: A replay sends the held bytes in arrival order, one complete frame each, in the same 8N1 format. The next byte is taken from the store only after the transmitter has gone idle. The replay ends when the store is empty.
- R9: Bytes received during a replay are stored if there is room. They are sent in the same replay when they arrive before the store runs empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial data from the host (idle high) |
| tx_o | output | 1 | Serial data to the host (idle high) |
| btn_i | input | 1 | Raw push-button level, high while pressed |
| buf_full_o | output | 1 | High while the store holds 256 bytes |

## Verification
The assertions check on every cycle that the store's fill count never exceeds its depth, and that the count stays unchanged when a write meets a full store with no read. They also check that every pop is handed to an idle transmitter, which then goes busy with a start bit, that a received byte is emitted only from the stop-bit state, and that a debounced press is a one-cycle pulse. Only the bench scenarios can show that the replayed stream matches what the host sent. The same holds for overflow keeping the first 256 bytes, glitches and bad stop bits storing nothing, bounce giving a single replay, and late arrivals joining a replay in progress. A behavioural model compares the line against these expectations on every clock.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int OSR = 16;
  localparam int OSR_W = $clog2(OSR);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_WAIT} seq_state_e;
endpackage

// File: rtl/cr_uart_rx.sv
module cr_uart_rx
  import cr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  output logic       out_valid_o,
  output logic [7:0] out_data_o
);
  localparam logic [OSR_W-1:0] HALF_M1 = OSR_W'(OSR/2 - 1);
  localparam logic [OSR_W-1:0] FULL_M1 = OSR_W'(OSR - 1);

  logic rx_m, rx_s;
  rx_state_e st;
  logic [OSR_W-1:0] cnt;
  logic [2:0] bit_idx;
  logic [7:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= RX_IDLE;
      cnt         <= '0;
      bit_idx     <= '0;
      sh          <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (!rx_s) begin
            st  <= RX_START;
            cnt <= '0;
          end
        end
        RX_START: begin
          if (tick_i) begin
            if (cnt == HALF_M1) begin
              cnt     <= '0;
              bit_idx <= '0;
              st      <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick_i) begin
            if (cnt == FULL_M1) begin
              cnt     <= '0;
              sh      <= {rx_s, sh[7:1]};
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == 3'd7) st <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick_i) begin
            if (cnt == FULL_M1) begin
              cnt         <= '0;
              out_valid_o <= rx_s;
              st          <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign out_data_o = sh;

  // R4: a byte is only emitted on leaving the stop-bit state
  a_r4_valid_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (st == RX_IDLE && $past(st) == RX_STOP));
endmodule

// File: rtl/cr_uart_tx.sv
module cr_uart_tx
  import cr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic [7:0] in_data_i,
  output logic       tx_o
);
  localparam logic [OSR_W-1:0] FULL_M1 = OSR_W'(OSR - 1);

  logic busy;
  logic [9:0] frame;
  logic [3:0] idx;
  logic [OSR_W-1:0] tc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy  <= 1'b0;
      frame <= '1;
      idx   <= '0;
      tc    <= '0;
    end else if (!busy) begin
      if (in_valid_i) begin
        busy  <= 1'b1;
        frame <= {1'b1, in_data_i, 1'b0};
        idx   <= '0;
        tc    <= '0;
      end
    end else if (tick_i) begin
      if (tc == FULL_M1) begin
        tc    <= '0;
        frame <= {1'b1, frame[9:1]};
        if (idx == 4'd9) busy <= 1'b0;
        else             idx  <= idx + 1'b1;
      end else begin
        tc <= tc + 1'b1;
      end
    end
  end

  assign in_ready_o = !busy;
  assign tx_o       = busy ? frame[0] : 1'b1;

  // R8: an accepted byte starts a frame with a low start bit
  a_r8_accept_starts_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (!in_ready_o && !tx_o));
endmodule

// File: rtl/cr_fifo.sv
module cr_fifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             full_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [WIDTH-1:0] rd_data_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic push, pop;

  assign full_o     = (count == CW'(DEPTH));
  assign rd_valid_o = (count != '0);
  assign push       = wr_valid_i && !full_o;
  assign pop        = rd_valid_o && rd_ready_i;
  assign rd_data_o  = mem[rptr];

  always_ff @(posedge clk_i) begin
    if (push) mem[wptr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5: a write into a full store changes nothing
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && full_o && !rd_ready_i) |=> (count == $past(count)));
  // R5: fill level bounded by the depth
  a_r5_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));
endmodule

// File: rtl/cr_debounce.sv
module cr_debounce #(
  parameter int DB_CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic press_o
);
  localparam int CNT_W = $clog2(DB_CYC + 1);

  logic b_m, b_s, stable, stable_d;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_m      <= 1'b0;
      b_s      <= 1'b0;
      stable   <= 1'b0;
      stable_d <= 1'b0;
      cnt      <= '0;
    end else begin
      b_m      <= btn_i;
      b_s      <= b_m;
      stable_d <= stable;
      if (b_s == stable) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(DB_CYC - 1)) begin
        cnt    <= '0;
        stable <= b_s;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign press_o = stable && !stable_d;

  // R7: a press gives a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o);
endmodule

// File: rtl/cr_capture_replay.sv
module cr_capture_replay
  import cr_pkg::*;
#(
  parameter int CLK_HZ      = 50000000,
  parameter int BAUD        = 115200,
  parameter int DEPTH       = 256,
  parameter int DEBOUNCE_US = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic tx_o,
  input  logic btn_i,
  output logic buf_full_o
);
  localparam int TICK_RAW = CLK_HZ / (BAUD * OSR);
  localparam int TICK_DIV = (TICK_RAW < 1) ? 1 : TICK_RAW;
  localparam longint DB_RAW = (longint'(CLK_HZ) / 1000) * DEBOUNCE_US / 1000;
  localparam int DB_CYC = (DB_RAW < 2) ? 2 : int'(DB_RAW);

  logic tick;
  generate
    if (TICK_DIV == 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int TW = $clog2(TICK_DIV);
      logic [TW-1:0] tcnt;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tcnt <= '0;
        else if (tcnt == TW'(TICK_DIV - 1)) tcnt <= '0;
        else tcnt <= tcnt + 1'b1;
      end
      assign tick = (tcnt == TW'(TICK_DIV - 1));
    end
  endgenerate

  logic       rx_valid;
  logic [7:0] rx_data;
  logic       q_valid, q_ready;
  logic [7:0] q_data;
  logic       tx_valid, tx_ready;
  logic       press;
  seq_state_e sq;

  cr_uart_rx i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx_i),
    .out_valid_o(rx_valid), .out_data_o(rx_data)
  );

  cr_fifo #(.DEPTH(DEPTH), .WIDTH(8)) i_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_valid_i(rx_valid), .wr_data_i(rx_data), .full_o(buf_full_o),
    .rd_valid_o(q_valid), .rd_ready_i(q_ready), .rd_data_o(q_data)
  );

  cr_debounce #(.DB_CYC(DB_CYC)) i_btn (
    .clk_i(clk_i), .rst_ni(rst_ni), .btn_i(btn_i), .press_o(press)
  );

  cr_uart_tx i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .in_valid_i(tx_valid), .in_ready_o(tx_ready), .in_data_i(q_data),
    .tx_o(tx_o)
  );

  assign tx_valid = (sq == SQ_SEND) && q_valid;
  assign q_ready  = (sq == SQ_SEND) && tx_ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq <= SQ_IDLE;
    end else begin
      case (sq)
        SQ_IDLE: if (press && q_valid) sq <= SQ_SEND;
        SQ_SEND: begin
          if (!q_valid)      sq <= SQ_IDLE;
          else if (tx_ready) sq <= SQ_WAIT;
        end
        default: if (tx_ready) sq <= SQ_SEND;
      endcase
    end
  end

  // R8: a pop always lands in an idle transmitter, which then goes busy
  a_r8_pop_to_idle_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_valid && q_ready) |=> !tx_ready);
  // R6: the transmitter only starts a frame while replaying
  a_r6_no_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq == SQ_IDLE) |-> !tx_valid);
endmodule

// File: tb/test_cr_capture_replay.sv
`timescale 1ns/1ps
module test_cr_capture_replay;
  localparam int BIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic btn = 1'b0;
  logic tx, full;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit tx_allowed = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  always #2.5 clk = ~clk;

  cr_capture_replay #(.CLK_HZ(1600000), .BAUD(100000), .DEPTH(256), .DEBOUNCE_US(10))
    i_cr_capture_replay (
      .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tx_o(tx),
      .btn_i(btn), .buf_full_o(full)
    );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic stop = 1'b1);
    @(negedge clk);
    rx = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i]; repeat (BIT) @(negedge clk);
    end
    rx = stop; repeat (BIT) @(negedge clk);
    rx = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic press();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) btn = 1'b1; repeat (3) @(negedge clk);
      btn = 1'b0; repeat (3) @(negedge clk);
    end
    btn = 1'b1; repeat (60) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      btn = 1'b0; repeat (3) @(negedge clk);
      btn = 1'b1; repeat (3) @(negedge clk);
    end
    btn = 1'b0; repeat (60) @(negedge clk);
  endtask

  task automatic collect(input string req);
    int guard = 0;
    while (got_q.size() < exp_q.size() && guard < 60000) begin
      @(negedge clk); guard++;
    end
    repeat (400) @(negedge clk);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    tx_allowed = 1'b0;
    got_q.delete();
    exp_q.delete();
  endtask

  // Behavioural line decoder for the transmit side (R2, R8)
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && tx === 1'b0) begin
        repeat (BIT/2 - 1) @(negedge clk);
        chk(tx === 1'b0, "R8 start bit", tx, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          b[i] = tx;
        end
        repeat (BIT) @(negedge clk);
        chk(tx === 1'b1, "R8 stop bit", tx, 1);
        got_q.push_back(b);
      end
    end
  end

  // Per-clock model: outside a replay window the line stays idle (R6)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !tx_allowed) chk(tx === 1'b1, "R6 no echo", tx, 1);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx === 1'b1, "R1 tx in reset", tx, 1);
    chk(full === 1'b0, "R1 full in reset", full, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx === 1'b1, "R1 tx after reset", tx, 1);
    chk(full === 1'b0, "R1 full after reset", full, 0);

    // R1/R7: press with an empty store sends nothing
    tx_allowed = 1'b1;
    press();
    collect("R1 empty press");

    // R3: short low glitch; R2 normal frames; R4 bad stop bit
    @(negedge clk) rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (40) @(negedge clk);
    send(8'hA5); send(8'h3C); send(8'h77, 1'b0);
    repeat (40) @(negedge clk);
    send(8'h00); send(8'hFF); send(8'h81);
    chk(full === 1'b0, "R5 not full", full, 0);
    repeat (100) @(negedge clk);
    exp_q = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81};
    tx_allowed = 1'b1;
    press(); // R7 bounce gives a single replay
    collect("R2 R3 R4 R7 R8 order");

    // R5: fill to capacity, overflow is dropped
    for (int i = 0; i < 256; i++) begin
      send(8'((i * 7) + 1));
      exp_q.push_back(8'((i * 7) + 1));
    end
    repeat (4) @(negedge clk);
    chk(full === 1'b1, "R5 full at 256", full, 1);
    for (int i = 0; i < 4; i++) send(8'hEE);
    chk(full === 1'b1, "R5 full after overflow", full, 1);
    tx_allowed = 1'b1;
    press();
    chk(full === 1'b0, "R5 full clears on replay", full, 0);
    collect("R5 first 256 kept");

    // R9: bytes arriving during a replay join it; R7 press during replay ignored
    for (int i = 0; i < 6; i++) begin
      send(8'h10 + 8'(i));
      exp_q.push_back(8'h10 + 8'(i));
    end
    exp_q.push_back(8'h5A);
    exp_q.push_back(8'hC3);
    tx_allowed = 1'b1;
    fork
      begin press(); repeat (100) @(negedge clk); press(); end
      begin repeat (30) @(negedge clk); send(8'h5A); send(8'hC3); end
    join
    collect("R9 late bytes R7 busy press");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule